// File: doc/BRIEF.md
# Router Link Power Gating Controller

This block lives inside a router and decides, one fixed-length interval at a time, which of the router's output links are powered. For every output port it counts the cycles in which a flit actually crossed the link. At each interval boundary it turns each count into a small unsigned utilization figure and publishes all of them together in one report, which an external predictor consumes.

The predictor answers with a threshold. Any link that was carrying traffic and whose last reported utilization is below that threshold is switched off for the whole of the following interval. A link that was unavailable at any point of an interval reports the full-utilization sentinel, so it cannot be chosen again straight away. Bringing a link back costs a fixed wake-up time: during that time the link is powered but carries nothing. Traffic that is aimed at a link that cannot carry it is held back through a per-port stall signal.

Top module: `link_gate_ctrl`

## Requirements
- R1: Utilization is `min(31, floor(count * RCP / 65536))`, where `count` is the number of transfer cycles in the interval and `RCP = ceil(31 * 65536 / INTERVAL)`. A port that transfers in every cycle reports 31.
- R2: `rpt_valid_o` is a one-cycle pulse in the first cycle of every interval after the first. Intervals are INTERVAL cycles long and start when reset is released. Each report covers only the interval that has just ended.
- R3: A threshold on `thr_i` is taken in any cycle where `thr_valid_i` is high. A link that is usable and has a last reported utilization strictly below the threshold goes unpowered (`link_pwr_o`=0, `link_ready_o`=0) from the first cycle of the next interval, for exactly one interval. Links switch off only at interval boundaries.
- R4: A link that was not usable (`link_ready_o`=0) in any cycle of an interval reports 31 for that interval. A link that is unusable when a threshold arrives is never selected to switch off.
- R5: If no threshold arrives during an interval, every unpowered link starts waking at the next boundary, and every usable link stays usable.
- R6: Waking lasts WAKE_CYCLES cycles, with `link_pwr_o`=1 and `link_ready_o`=0. `link_ready_o` then rises exactly WAKE_CYCLES cycles after the boundary where waking began. A link never becomes usable directly from unpowered.
- R7: `stall_o[p]` is high in the same cycle whenever `flit_req_i[p]` is high and link p is not usable. Held cycles are not counted as transfers.
- R8: During and right after reset, all links are powered and usable, `rpt_valid_o` is 0 and every utilization field reads 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_req_i | input | 4 | Per port: a flit is waiting to leave on this link |
| thr_valid_i | input | 1 | A threshold message is present this cycle |
| thr_i | input | 5 | Threshold utilization |
| rpt_valid_o | output | 1 | Report pulse at the interval boundary |
| rpt_util_o | output | 20 | Utilization per port, port p in bits [5p+4:5p] |
| link_pwr_o | output | 4 | Per link: powered (usable or waking) |
| link_ready_o | output | 4 | Per link: usable for traffic |
| stall_o | output | 4 | Per port: waiting flit is being held back |

## Verification
The report is due in the first cycle of the interval that follows the one being measured, which is INTERVAL rising edges after that interval began. Link state changes appear in that same cycle. A waking link becomes usable exactly WAKE_CYCLES cycles after its boundary, and the stall responds within the cycle in which a request appears. The bench therefore counts whole intervals from the release of reset. It drives inputs on falling edges and samples one nanosecond later. Reports and link masks are checked in cycle 0 of each interval, the end of the report pulse in cycle 1, and usability again in the last cycle, so that the wake-up boundary is pinned on both sides.

// File: rtl/lgc_pkg.sv
package lgc_pkg;

  typedef enum logic [1:0] {
    LS_ON     = 2'd0,
    LS_OFF    = 2'd1,
    LS_WAKING = 2'd2
  } link_state_e;

  // Fixed-point reciprocal of the interval, scaled to full-scale utilization.
  // Rounded up so that a fully busy interval reaches full scale.
  function automatic int unsigned recip_of(input int unsigned interval,
                                           input int unsigned full,
                                           input int unsigned frac_w);
    return ((full << frac_w) + interval - 1) / interval;
  endfunction

  // Busy count times reciprocal, dropped to integer, saturated at full scale.
  function automatic int unsigned scale_util(input int unsigned count,
                                             input int unsigned recip,
                                             input int unsigned frac_w,
                                             input int unsigned full);
    int unsigned prod;
    prod = (count * recip) >> frac_w;
    return (prod > full) ? full : prod;
  endfunction

endpackage

// File: rtl/lgc_interval_timer.sv
module lgc_interval_timer #(
  parameter int unsigned INTERVAL = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] phase_q;

  assign tick_o = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      phase_q <= '0;
    else if (tick_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/lgc_util_meter.sv
module lgc_util_meter #(
  parameter int unsigned INTERVAL = 100,
  parameter int unsigned UTIL_W   = 5,
  parameter int unsigned FRAC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              xfer_i,
  input  logic              not_ready_i,
  output logic [UTIL_W-1:0] util_o,
  output logic              eligible_o
);
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1);
  localparam int unsigned FULL  = (1 << UTIL_W) - 1;
  localparam int unsigned RECIP = lgc_pkg::recip_of(INTERVAL, FULL, FRAC_W);

  logic [CNT_W-1:0]  busy_q;
  logic              blocked_q;
  logic [CNT_W-1:0]  busy_now_w;
  logic              blocked_now_w;
  logic [UTIL_W-1:0] util_next_w;

  assign busy_now_w    = busy_q + CNT_W'(xfer_i);
  assign blocked_now_w = blocked_q | not_ready_i;
  assign util_next_w   = blocked_now_w ? UTIL_W'(FULL)
                       : UTIL_W'(lgc_pkg::scale_util(32'(busy_now_w), RECIP, FRAC_W, FULL));
  assign eligible_o    = ~blocked_now_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= '0;
      blocked_q <= 1'b0;
      util_o    <= UTIL_W'(FULL);
    end else if (tick_i) begin
      busy_q    <= '0;
      blocked_q <= 1'b0;
      util_o    <= util_next_w;
    end else begin
      busy_q    <= busy_now_w;
      blocked_q <= blocked_now_w;
    end
  end
endmodule

// File: rtl/lgc_link_fsm.sv
module lgc_link_fsm #(
  parameter int unsigned WAKE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic go_off_i,
  output logic ready_o,
  output logic pwr_o,
  output logic wake_done_o
);
  import lgc_pkg::*;
  localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] WAKE_LOAD = WW'(WAKE_CYCLES - 1);

  link_state_e    state_q;
  logic [WW-1:0]  wait_q;

  assign ready_o     = (state_q == LS_ON);
  assign pwr_o       = (state_q != LS_OFF);
  assign wake_done_o = (state_q == LS_WAKING) && (wait_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LS_ON;
      wait_q  <= '0;
    end else begin
      case (state_q)
        LS_ON: begin
          if (tick_i && go_off_i) state_q <= LS_OFF;
        end
        LS_OFF: begin
          if (tick_i && !go_off_i) begin
            state_q <= LS_WAKING;
            wait_q  <= WAKE_LOAD;
          end
        end
        LS_WAKING: begin
          if (tick_i && go_off_i) state_q <= LS_OFF;
          else if (wake_done_o)   state_q <= LS_ON;
          else                    wait_q  <= wait_q - 1'b1;
        end
        default: state_q <= LS_ON;
      endcase
    end
  end
endmodule

// File: rtl/link_gate_ctrl.sv
module link_gate_ctrl #(
  parameter int unsigned NUM_PORTS   = 4,
  parameter int unsigned INTERVAL    = 100,
  parameter int unsigned WAKE_CYCLES = 100,
  parameter int unsigned UTIL_W      = 5,
  parameter int unsigned FRAC_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PORTS-1:0]          flit_req_i,
  input  logic                          thr_valid_i,
  input  logic [UTIL_W-1:0]             thr_i,
  output logic                          rpt_valid_o,
  output logic [NUM_PORTS*UTIL_W-1:0]   rpt_util_o,
  output logic [NUM_PORTS-1:0]          link_pwr_o,
  output logic [NUM_PORTS-1:0]          link_ready_o,
  output logic [NUM_PORTS-1:0]          stall_o
);
  logic                 tick_w;
  logic [NUM_PORTS-1:0] xfer_w;
  logic [NUM_PORTS-1:0] eligible_w;
  logic [NUM_PORTS-1:0] below_w;
  logic [NUM_PORTS-1:0] go_off_w;
  logic [NUM_PORTS-1:0] wake_done_w;
  logic [NUM_PORTS-1:0] pend_off_q;

  lgc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  assign xfer_w  = flit_req_i & link_ready_o;
  assign stall_o = flit_req_i & ~link_ready_o;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    lgc_util_meter #(.INTERVAL(INTERVAL), .UTIL_W(UTIL_W), .FRAC_W(FRAC_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_w),
      .xfer_i(xfer_w[p]), .not_ready_i(~link_ready_o[p]),
      .util_o(rpt_util_o[p*UTIL_W +: UTIL_W]), .eligible_o(eligible_w[p])
    );

    assign below_w[p]  = eligible_w[p] && (rpt_util_o[p*UTIL_W +: UTIL_W] < thr_i);
    assign go_off_w[p] = thr_valid_i ? below_w[p] : pend_off_q[p];

    lgc_link_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .go_off_i(go_off_w[p]),
      .ready_o(link_ready_o[p]), .pwr_o(link_pwr_o[p]), .wake_done_o(wake_done_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_off_q  <= '0;
      rpt_valid_o <= 1'b0;
    end else begin
      rpt_valid_o <= tick_w;
      if (tick_w)           pend_off_q <= '0;
      else if (thr_valid_i) pend_off_q <= below_w;
    end
  end
endmodule

// File: rtl/lgc_chk.sv
module lgc_chk #(
  parameter int unsigned NP     = 4,
  parameter int unsigned UTIL_W = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NP-1:0]          flit_req_i,
  input logic                   rpt_valid_o,
  input logic [NP*UTIL_W-1:0]   rpt_util_o,
  input logic [NP-1:0]          link_pwr_o,
  input logic [NP-1:0]          link_ready_o,
  input logic [NP-1:0]          stall_o
);
  localparam logic [UTIL_W-1:0] FULL = '1;

  // R2
  rpt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_o |=> !rpt_valid_o);

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R4
    sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rpt_valid_o && !$past(link_ready_o[p])) |-> (rpt_util_o[p*UTIL_W +: UTIL_W] == FULL));
    // R3
    off_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_pwr_o[p]) |-> rpt_valid_o);
    // R6
    wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_ready_o[p]) |-> $past(link_pwr_o[p]));
    // R6
    unpowered_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_pwr_o[p] |-> !link_ready_o[p]);
    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o[p] |-> (flit_req_i[p] && !link_ready_o[p]));
  end
endmodule

bind link_gate_ctrl lgc_chk #(.NP(NUM_PORTS), .UTIL_W(UTIL_W)) u_lgc_chk (
  .clk(clk), .rst_n(rst_n), .flit_req_i(flit_req_i), .rpt_valid_o(rpt_valid_o),
  .rpt_util_o(rpt_util_o), .link_pwr_o(link_pwr_o), .link_ready_o(link_ready_o),
  .stall_o(stall_o)
);

// File: tb/test_link_gate_ctrl.sv
module test_link_gate_ctrl;
  localparam int NP = 4;
  localparam int IV = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] req = '0;
  logic          thr_valid = 1'b0;
  logic [4:0]    thr = '0;
  logic          rpt_valid;
  logic [19:0]   rpt_util;
  logic [NP-1:0] pwr, ready, stall;

  int n_cmp = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  link_gate_ctrl i_link_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .flit_req_i(req), .thr_valid_i(thr_valid), .thr_i(thr),
    .rpt_valid_o(rpt_valid), .rpt_util_o(rpt_util), .link_pwr_o(pwr),
    .link_ready_o(ready), .stall_o(stall)
  );

  typedef struct packed {
    logic [7:0] c0, c1, c2, c3;
    logic       ten;
    logic [4:0] thr;
    logic [3:0] rdy;
    logic [3:0] pwr;
  } vec_t;

  // Per interval: busy request cycles per port, threshold, and the expected usable/powered masks.
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'd0,   8'd50, 8'd100, 8'd10,  1'b0, 5'd0,  4'b1111, 4'b1111},
    '{8'd20,  8'd80, 8'd5,   8'd100, 1'b1, 5'd10, 4'b1111, 4'b1111},
    '{8'd30,  8'd30, 8'd30,  8'd30,  1'b1, 5'd20, 4'b0110, 4'b0110},
    '{8'd40,  8'd40, 8'd40,  8'd40,  1'b0, 5'd0,  4'b0010, 4'b1011},
    '{8'd100, 8'd0,  8'd60,  8'd70,  1'b1, 5'd31, 4'b1011, 4'b1111},
    '{8'd0,   8'd0,  8'd0,   8'd0,   1'b1, 5'd0,  4'b1101, 4'b1101},
    '{8'd0,   8'd0,  8'd0,   8'd0,   1'b0, 5'd0,  4'b1101, 4'b1111},
    '{8'd0,   8'd0,  8'd0,   8'd0,   1'b0, 5'd0,  4'b1111, 4'b1111},
    '{8'd0,   8'd0,  8'd0,   8'd0,   1'b1, 5'd5,  4'b1111, 4'b1111},
    '{8'd0,   8'd0,  8'd0,   8'd0,   1'b0, 5'd0,  4'b0000, 4'b0000}
  };

  task automatic chk(input string req_tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int cnt_of(input vec_t v, input int p);
    case (p)
      0: return int'(v.c0);
      1: return int'(v.c1);
      2: return int'(v.c2);
      default: return int'(v.c3);
    endcase
  endfunction

  // R1: scaled utilization from the count of transfer cycles.
  function automatic int exp_util(input int c);
    int rcp, u;
    rcp = (31 * 65536 + IV - 1) / IV;
    u = (c * rcp) / 65536;
    return (u > 31) ? 31 : u;
  endfunction

  task automatic chk_report(input vec_t v);
    chk("R2 report pulse", int'(rpt_valid), 1);
    for (int p = 0; p < NP; p++) begin
      if (v.rdy[p]) chk("R1 utilization", int'(rpt_util[p*5 +: 5]), exp_util(cnt_of(v, p)));
      else          chk("R4 sentinel", int'(rpt_util[p*5 +: 5]), 31);
    end
  endtask

  initial begin
    #100000;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R8: reset state
    chk("R8 ready", int'(ready), 15);
    chk("R8 pwr", int'(pwr), 15);
    chk("R8 valid", int'(rpt_valid), 0);
    chk("R8 util", int'(rpt_util), 20'hFFFFF);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      for (int i = 0; i < IV; i++) begin
        for (int p = 0; p < NP; p++) req[p] = (i < cnt_of(VEC[k], p));
        thr_valid = VEC[k].ten && (i == 5);
        thr = VEC[k].thr;
        #1;
        if (i == 0) begin
          if (k > 0) chk_report(VEC[k-1]);
          else       chk("R2 no report in first interval", int'(rpt_valid), 0);
          chk("R3 R5 powered mask", int'(pwr), int'(VEC[k].pwr));
          chk("R3 R6 usable mask", int'(ready), int'(VEC[k].rdy));
          for (int p = 0; p < NP; p++)
            chk("R7 stall", int'(stall[p]),
                int'((cnt_of(VEC[k], p) > 0) && !VEC[k].rdy[p]));
        end
        if (i == 1)  chk("R2 pulse ends", int'(rpt_valid), 0);
        if (i == IV-1) chk("R6 usable at last cycle", int'(ready), int'(VEC[k].rdy));
        @(negedge clk);
      end
    end
    req = '0;
    thr_valid = 1'b0;
    #1;
    // R4: all links were off for the last interval, R5: no threshold so all wake
    chk_report(VEC[NV-1]);
    chk("R5 waking powered", int'(pwr), 15);
    chk("R6 waking not usable", int'(ready), 0);
    req = 4'b1010;
    #1;
    chk("R7 stall while waking", int'(stall), 10);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    // R8: reset in mid-operation
    chk("R8 ready after reset", int'(ready), 15);
    chk("R8 pwr after reset", int'(pwr), 15);
    chk("R8 valid after reset", int'(rpt_valid), 0);
    chk("R8 util after reset", int'(rpt_util), 20'hFFFFF);
    chk("R7 no stall after reset", int'(stall), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule